// File: doc/BRIEF.md
# Guarded Four-Phase Rule Engine

This block joins two 16-bit input channels and one 16-bit output channel. Every channel uses a four-phase request/acknowledge pair with a data bus. A one-bit state flag tracks which of two rules is due.

A rule fires when all of its channel conditions and its guard on the flag are true in the same clock cycle. On that single clock edge it consumes its inputs, launches its output and updates the flag.

- With the flag empty, the sum rule takes one word from each input. It sends their 16-bit truncated sum and sets the flag.
- With the flag full, the pass rule takes one word from input A only. It sends that word and clears the flag.

The pass rule's output port has a conditional trigger that depends on the data. A zero word on input A makes the output port count as satisfied. No output handshake takes place, and the word is consumed and dropped.

A parameter selects how rules are evaluated:
- In priority mode, rules are tested in a fixed order and at most one fires per cycle.
- In parallel mode, every rule whose conditions hold fires.

Each input channel is acknowledged once per word and released after its request falls. Each output word is held stable until the receiver acknowledges it.

Top module: `hsRuleEngine`

## Requirements
- R1: While `rstN` is low at a clock edge, both input acknowledges go to 1 and `yReq` goes to 0. If `CLEAR_DATA` is 1, `yData` also goes to 0.
- R2: An input acknowledge rises only on a clock edge where that channel's request is high, its acknowledge is low and a rule consuming that channel fires. It falls on the first clock edge where its request is low and the acknowledge is high.
- R3: `yReq` rises only when a rule sends. It falls on the first clock edge where `yReq` and `yAck` are both high. `yData` does not change while `yReq` stays high.
- R4: With the flag empty, A and B both ready, and the output free (`yReq` and `yAck` both low), the sum rule fires. It sends `(aData + bData) mod 2^16` and sets the flag.
- R5: With the flag full and A ready, the pass rule fires. It consumes A only, clears the flag and never acknowledges B.
- R6: If the pass rule sees `aData` equal to 0, it still consumes A and clears the flag, but it neither waits for nor drives the output channel. Nonzero words do need a free output channel.
- R7: All actions of a rule take effect on the same clock edge. In priority mode (`PRIORITY_MODE=1`) no two rules fire in the same cycle.
- R8: Every expected output word appears on the output channel exactly once and in input order, and no extra word appears.
- R9: The flag's reset value is set by `FLAG_INIT`. With the default of 0, the first rule after reset is the sum rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| aReq | input | 1 | Input A request |
| aAck | output | 1 | Input A acknowledge |
| aData | input | 16 | Input A data |
| bReq | input | 1 | Input B request |
| bAck | output | 1 | Input B acknowledge |
| bData | input | 16 | Input B data |
| yReq | output | 1 | Output request |
| yAck | input | 1 | Output acknowledge |
| yData | output | 16 | Output data, registered |

## Verification
A wrong flag value shows up at the output within one word: the wrong rule fires. A sum appears where an A word should pass through, or B is acknowledged when it should not be. Either breaks the in-order comparison at that position.

An acknowledge or request that returns to zero late or never stalls the matching channel on its next word. The bench checks the edge one cycle after the release and so catches this. A lost conditional trigger either stalls the stream on a zero word or emits a spurious zero word. Both are caught by the exact-count comparison.

// File: rtl/hsRulePkg.sv
package hsRulePkg;

  // strobes from control to datapath, one per loadable source of the output register
  typedef struct packed {
    logic loadSum;
    logic loadPass;
  } dpStrobe_t;

endpackage

// File: rtl/hsRuleCtrl.sv
module hsRuleCtrl
  import hsRulePkg::*;
#(
  parameter bit PRIORITY_MODE = 1'b1,
  parameter bit FLAG_INIT     = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      aReq,
  input  logic      bReq,
  input  logic      yAckIn,
  input  logic      passNonZero,
  output logic      aAckQ,
  output logic      bAckQ,
  output logic      yReqQ,
  output dpStrobe_t strobe
);

  localparam int NUM_RULES = 2;
  localparam int RULE_SUM  = 0;
  localparam int RULE_PASS = 1;

  logic flagQ;
  logic aReady, bReady, yFree;
  logic passOutCond, passOutOk;
  logic [NUM_RULES-1:0] ruleGo;
  logic [NUM_RULES-1:0] ruleFire;

  // channel readiness
  assign aReady = aReq && !aAckQ;
  assign bReady = bReq && !bAckQ;
  assign yFree  = !yReqQ && !yAckIn;

  // conditional trigger: output port only matters for a nonzero pass word
  assign passOutCond = passNonZero;
  assign passOutOk   = passOutCond ? yFree : 1'b1;

  assign ruleGo[RULE_SUM]  = aReady && bReady && yFree && !flagQ;
  assign ruleGo[RULE_PASS] = aReady && passOutOk && flagQ;

  generate
    if (PRIORITY_MODE) begin : gPriority
      always_comb begin
        ruleFire = '0;
        for (int r = 0; r < NUM_RULES; r++) begin
          if (ruleGo[r] && (ruleFire == '0)) ruleFire[r] = 1'b1;
        end
      end
    end else begin : gParallel
      assign ruleFire = ruleGo;
    end
  endgenerate

  assign strobe.loadSum  = ruleFire[RULE_SUM];
  assign strobe.loadPass = ruleFire[RULE_PASS] && passOutCond;

  // return-to-zero first, rule actions afterwards so they win
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aAckQ <= 1'b1;
      bAckQ <= 1'b1;
      yReqQ <= 1'b0;
      flagQ <= FLAG_INIT;
    end else begin
      if (!aReq && aAckQ) aAckQ <= 1'b0;
      if (!bReq && bAckQ) bAckQ <= 1'b0;
      if (yReqQ && yAckIn) yReqQ <= 1'b0;
      if (ruleFire[RULE_SUM]) begin
        aAckQ <= 1'b1;
        bAckQ <= 1'b1;
        yReqQ <= 1'b1;
        flagQ <= 1'b1;
      end
      if (ruleFire[RULE_PASS]) begin
        aAckQ <= 1'b1;
        if (passOutCond) yReqQ <= 1'b1;
        flagQ <= 1'b0;
      end
    end
  end

  AST_A_ACK_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aAckQ) |-> $past(aReq)); // R2
  AST_B_ACK_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bAckQ) |-> $past(bReq)); // R2
  AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (yReqQ && !yAckIn) |=> yReqQ); // R3
  AST_SUM_FILLS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ruleFire[RULE_SUM] |=> (flagQ && aAckQ && bAckQ && yReqQ)); // R4
  AST_PASS_SPARES_B: assert property (@(posedge clk) disable iff (!rstN)
    ruleFire[RULE_PASS] |=> (!flagQ && aAckQ && !$rose(bAckQ))); // R5
  AST_ZERO_PASS_NO_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (ruleFire[RULE_PASS] && !passOutCond && !yReqQ) |=> !yReqQ); // R6
  AST_ONE_RULE: assert property (@(posedge clk) disable iff (!rstN)
    PRIORITY_MODE |-> $onehot0(ruleFire)); // R7

endmodule

// File: rtl/hsRuleDatapath.sv
module hsRuleDatapath
  import hsRulePkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit CLEAR_DATA = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] aData,
  input  logic [WIDTH-1:0] bData,
  output logic [WIDTH-1:0] yDataQ,
  output logic             passNonZero
);

  localparam int SUM_W = WIDTH + 1;

  logic [SUM_W-1:0] sumFull;
  logic [WIDTH-1:0] nextData;

  assign sumFull     = {1'b0, aData} + {1'b0, bData};
  assign passNonZero = (aData != '0);

  always_comb begin
    nextData = yDataQ;
    if (strobe.loadSum)       nextData = sumFull[WIDTH-1:0];
    else if (strobe.loadPass) nextData = aData;
  end

  generate
    if (CLEAR_DATA) begin : gClear
      always_ff @(posedge clk) begin
        if (!rstN) yDataQ <= '0;
        else       yDataQ <= nextData;
      end
    end else begin : gKeep
      always_ff @(posedge clk) yDataQ <= nextData;
    end
  endgenerate

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadSum && strobe.loadPass)); // R7

endmodule

// File: rtl/hsRuleEngine.sv
module hsRuleEngine
  import hsRulePkg::*;
#(
  parameter int WIDTH         = 16,
  parameter bit PRIORITY_MODE = 1'b1,
  parameter bit FLAG_INIT     = 1'b0,
  parameter bit CLEAR_DATA    = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aReq,
  output logic             aAck,
  input  logic [WIDTH-1:0] aData,
  input  logic             bReq,
  output logic             bAck,
  input  logic [WIDTH-1:0] bData,
  output logic             yReq,
  input  logic             yAck,
  output logic [WIDTH-1:0] yData
);

  dpStrobe_t strobe;
  logic      passNonZero;

  hsRuleCtrl #(
    .PRIORITY_MODE(PRIORITY_MODE),
    .FLAG_INIT    (FLAG_INIT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .aReq       (aReq),
    .bReq       (bReq),
    .yAckIn     (yAck),
    .passNonZero(passNonZero),
    .aAckQ      (aAck),
    .bAckQ      (bAck),
    .yReqQ      (yReq),
    .strobe     (strobe)
  );

  hsRuleDatapath #(
    .WIDTH     (WIDTH),
    .CLEAR_DATA(CLEAR_DATA)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .aData      (aData),
    .bData      (bData),
    .yDataQ     (yData),
    .passNonZero(passNonZero)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (yReq && $past(yReq) && $past(rstN)) |-> $stable(yData)); // R3

endmodule

// File: tb/tb_hsRuleEngine.sv
`timescale 1ns/1ps
module tb_hsRuleEngine;

  localparam int W     = 16;
  localparam int NUM_A = 40;
  localparam int NUM_B = NUM_A / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aReq = 1'b0, bReq = 1'b0, yAck = 1'b0;
  logic [W-1:0] aData = '0, bData = '0;
  logic aAck, bAck, yReq;
  logic [W-1:0] yData;

  always #2.5 clk = ~clk;

  hsRuleEngine dut (
    .clk(clk), .rstN(rstN),
    .aReq(aReq), .aAck(aAck), .aData(aData),
    .bReq(bReq), .bAck(bAck), .bData(bData),
    .yReq(yReq), .yAck(yAck), .yData(yData)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [W-1:0] expVal [0:63];
  int expN = 0;
  int gotN = 0;
  int aRises = 0, bRises = 0;
  logic aAckD = 1'b1, bAckD = 1'b1;

  function automatic logic [W-1:0] valA(int i);
    if (i == 0) return 16'hFFFF;          // with valB(0)=1 wraps to 0
    if (i % 6 == 1) return '0;            // zero word on a pass slot
    return W'(i * 16'h1357 + 16'h0A0B);
  endfunction

  function automatic logic [W-1:0] valB(int j);
    return W'(j * 16'h0421 + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveA();
    for (int i = 0; i < NUM_A; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      aData = valA(i);
      aReq  = 1'b1;
      do @(negedge clk); while (!aAck);
      aReq = 1'b0;
      @(negedge clk);
      check("R2 a ack release", {31'b0, aAck}, 32'd0);
    end
  endtask

  task automatic driveB();
    for (int j = 0; j < NUM_B; j++) begin
      repeat ($urandom_range(0, 5)) @(negedge clk);
      bData = valB(j);
      bReq  = 1'b1;
      do @(negedge clk); while (!bAck);
      bReq = 1'b0;
      @(negedge clk);
      check("R2 b ack release", {31'b0, bAck}, 32'd0);
    end
  endtask

  task automatic sinkY();
    while (gotN < expN) begin
      do @(negedge clk); while (!yReq);
      check("R4 R5 R8 output word", {16'b0, yData}, {16'b0, expVal[gotN]});
      gotN++;
      repeat ($urandom_range(0, 4)) begin
        @(negedge clk);
        check("R3 data held", {16'b0, yData}, {16'b0, expVal[gotN-1]});
      end
      yAck = 1'b1;
      @(negedge clk);
      check("R3 req drop", {31'b0, yReq}, 32'd0);
      yAck = 1'b0;
    end
  endtask

  // handshake counters observed at the ports
  always @(negedge clk) begin
    if (rstN) begin
      if (aAck && !aAckD) aRises++;
      if (bAck && !bAckD) bRises++;
    end
    aAckD = aAck;
    bAckD = bAck;
  end

  initial begin
    // expected stream: even A words sum with the next B word, odd A words pass unless zero
    for (int i = 0; i < NUM_A; i++) begin
      if (i % 2 == 0) begin
        expVal[expN] = W'(valA(i) + valB(i / 2));
        expN++;
      end else if (valA(i) != '0) begin
        expVal[expN] = valA(i);
        expN++;
      end
    end

    repeat (3) @(negedge clk);
    check("R1 a ack in reset", {31'b0, aAck}, 32'd1);
    check("R1 b ack in reset", {31'b0, bAck}, 32'd1);
    check("R1 y req in reset", {31'b0, yReq}, 32'd0);
    check("R1 y data in reset", {16'b0, yData}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 a ack release after reset", {31'b0, aAck}, 32'd0);
    check("R2 b ack release after reset", {31'b0, bAck}, 32'd0);

    // only A offered first: flag resets empty, so nothing fires (R9)
    aData = valA(0);
    aReq  = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 no pass at reset flag", {31'b0, aAck}, 32'd0);
    check("R9 no output at reset flag", {31'b0, yReq}, 32'd0);
    aReq = 1'b0;

    fork
      driveA();
      driveB();
      sinkY();
    join

    repeat (30) @(negedge clk);
    check("R8 no extra output", {31'b0, yReq}, 32'd0);
    check("R8 word count", gotN, expN);
    check("R2 R6 a handshakes", aRises, NUM_A);
    check("R5 b handshakes", bRises, NUM_B);
    check("R7 expected length", expN, 33);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule